// File: doc/BRIEF.md
# Magic-Sequence Watchdog Timer

A watchdog counter that must be fed by software through a small 32-bit register port. Software picks a power-of-two timeout with a 5-bit delay field and arms the counter with an enable bit. To keep the system running it writes one fixed 32-bit word to a first kick register and then a second, different word to a second kick register. A counter that runs out, a malformed kick sequence, or a software soft-reset write each raise a reset request. The request lasts a fixed number of cycles.

The block records why the last reset happened in a 3-bit cause field. Only the power-on reset input clears this field, so boot software can read it after any watchdog-driven or user reset. An external user-reset input also updates the field. The whole block, including the register port, runs on the watchdog clock.

Top module: `wdog_kick`

## Requirements
- R1: After power-on reset `rst_req_o` is low, the cause field reads 0 (hard reset) and the configuration register reads 0.
- R2: The configuration register at offset 0x04 reads back the enable in bit 31 and the delay in bits [4:0]. All other bits read 0.
- R3: While armed, the reset request rises 2^(delay+1) cycles after the most recent restart (arming write, configuration write or valid kick), and the cause becomes 1 (timeout).
- R4: A valid kick restarts the count. A valid kick is 0xABCD1234 written to offset 0x08, with the very next register write being 0x4321DCBA to offset 0x0C. Regular kicks spaced closer than the timeout keep the request low.
- R5: Each of these raises the request on the next cycle and sets cause 2 (incorrect kick): a wrong value at 0x08; a write to 0x0C that does not directly follow a correct first word; a wrong value at 0x0C.
- R6: A write to offset 0x00 with bit 0 set raises the request on the next cycle and sets cause 3 (soft reset). A write there with bit 0 clear has no effect.
- R7: The reset request stays high for exactly 16 cycles after a single event.
- R8: The cause field reads in bits [2:0] of offset 0x08 and holds its value after the request ends. Only power-on reset clears it.
- R9: A pulse on `user_rst_i` sets the cause to 4 (user reset) and does not raise the request.
- R10: Clearing the enable bit does not stop the counter. The count keeps running and can still time out until the next valid kick, which then disarms it.
- R11: A block that was never enabled never raises a timeout.
- R12: Any configuration write restarts the count, so a new delay takes effect from that write rather than from the earlier start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Watchdog clock |
| rst_n | input | 1 | Power-on (hard) reset, active low |
| user_rst_i | input | 1 | External user-reset indication |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| rst_req_o | output | 1 | Reset request to the reset controller |

## Verification
A counter that is wrong or was not reloaded moves the rising edge of `rst_req_o` away from the cycle that 2^(delay+1) predicts. The bench therefore samples the cycle just before the expected edge and the cycle of the edge itself. A bad arming or first-word flag shows up within one cycle: a good kick raises the request, or a bad kick fails to raise it. A wrong cause register is visible at offset 0x08 as soon as the request is high, and stays visible long after the request has dropped.

// File: rtl/wdog_kick.sv
module wdog_kick #(
  parameter int unsigned PULSE_LEN = 16,
  parameter logic [31:0] MAGIC_A   = 32'hABCD1234,
  parameter logic [31:0] MAGIC_B   = 32'h4321DCBA
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        user_rst_i,
  input  logic        reg_we,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        rst_req_o
);
  localparam int PW = $clog2(PULSE_LEN + 1);
  localparam logic [3:0] OFS_SOFT = 4'h0, OFS_CFG = 4'h4, OFS_K1 = 4'h8, OFS_K2 = 4'hC;

  logic          en_q, armed_q, first_ok_q;
  logic [4:0]    dly_q;
  logic [31:0]   cnt_q;
  logic [2:0]    cause_q;
  logic [PW-1:0] pulse_q;

  wire wr_soft  = reg_we && reg_addr == OFS_SOFT && reg_wdata[0];
  wire wr_cfg   = reg_we && reg_addr == OFS_CFG;
  wire wr_k1    = reg_we && reg_addr == OFS_K1;
  wire wr_k2    = reg_we && reg_addr == OFS_K2;
  wire good_k1  = wr_k1 && reg_wdata == MAGIC_A;
  wire kick_ok  = wr_k2 && first_ok_q && reg_wdata == MAGIC_B;
  wire kick_bad = (wr_k1 && !good_k1) || (wr_k2 && !kick_ok);

  wire [31:0] limit  = ~(32'hFFFF_FFFE << dly_q);
  wire        expire = armed_q && cnt_q == limit && !kick_ok && !wr_cfg;
  wire        fire   = wr_soft || kick_bad || expire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q       <= 1'b0;
      armed_q    <= 1'b0;
      first_ok_q <= 1'b0;
      dly_q      <= '0;
      cnt_q      <= '0;
      cause_q    <= 3'd0;
      pulse_q    <= '0;
    end else begin
      if (reg_we) first_ok_q <= good_k1;

      if (wr_cfg) begin
        en_q  <= reg_wdata[31];
        dly_q <= reg_wdata[4:0];
        if (reg_wdata[31]) armed_q <= 1'b1;
      end else if (kick_ok && !en_q) begin
        armed_q <= 1'b0;
      end

      cnt_q <= (!armed_q || wr_cfg || kick_ok || expire) ? '0 : cnt_q + 32'd1;

      if (wr_soft)         cause_q <= 3'd3;
      else if (kick_bad)   cause_q <= 3'd2;
      else if (expire)     cause_q <= 3'd1;
      else if (user_rst_i) cause_q <= 3'd4;

      if (fire)              pulse_q <= PW'(PULSE_LEN);
      else if (pulse_q != 0) pulse_q <= pulse_q - 1'b1;
    end
  end

  assign rst_req_o = pulse_q != 0;

  always_comb begin
    case (reg_addr)
      OFS_CFG: reg_rdata = {en_q, 26'd0, dly_q};
      OFS_K1:  reg_rdata = {29'd0, cause_q};
      default: reg_rdata = 32'd0;
    endcase
  end
endmodule

module wdog_kick_chk #(
  parameter int unsigned PULSE_LEN = 16,
  parameter logic [31:0] MAGIC_A   = 32'hABCD1234
) (
  input logic        clk,
  input logic        rst_n,
  input logic        user_rst_i,
  input logic        reg_we,
  input logic [3:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic [2:0]  cause,
  input logic        req
);
  logic [15:0] hi_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   hi_cnt <= '0;
    else if (req) hi_cnt <= (hi_cnt == 16'hFFFF) ? hi_cnt : hi_cnt + 16'd1;
    else          hi_cnt <= '0;
  end

  AST_SOFT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 4'h0 && reg_wdata[0]) |=> (req && cause == 3'd3)); // R6
  AST_BAD_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 4'h8 && reg_wdata != MAGIC_A) |=> (req && cause == 3'd2)); // R5
  AST_CAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cause) |-> (req || $past(user_rst_i))); // R8
  AST_PULSE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req) |-> (hi_cnt >= 16'(PULSE_LEN))); // R7
endmodule

bind wdog_kick wdog_kick_chk #(.PULSE_LEN(PULSE_LEN), .MAGIC_A(MAGIC_A)) chk_i (
  .clk(clk), .rst_n(rst_n), .user_rst_i(user_rst_i), .reg_we(reg_we),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .cause(cause_q), .req(rst_req_o));

// File: tb/wdog_kick_tb_top.sv
module wdog_kick_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] KA = 32'hABCD1234, KB = 32'h4321DCBA;

  logic clk = 1'b0, rst_n = 1'b0, user_rst_i = 1'b0, reg_we = 1'b0;
  logic [3:0] reg_addr = 4'h0;
  logic [31:0] reg_wdata = 32'd0, reg_rdata;
  logic rst_req_o;
  int n_chk = 0, n_bad = 0;
  bit saw_req;

  wdog_kick dut_i (.clk(clk), .rst_n(rst_n), .user_rst_i(user_rst_i), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rst_req_o(rst_req_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) begin
      @(negedge clk);
      if (rst_req_o) saw_req = 1'b1;
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    if (rst_req_o) saw_req = 1'b1;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic hard_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    saw_req = 1'b0;
  endtask

  task automatic t_reset_state();
    logic [31:0] d;
    check("R1 req", {31'd0, rst_req_o}, 0);
    rd(4'h8, d); check("R1 cause", d, 0);
    rd(4'h4, d); check("R1 cfg", d, 0);
  endtask

  task automatic t_cfg_timeout();
    logic [31:0] d;
    hard_reset();
    wr(4'h4, 32'hFFFF_FFE4);
    rd(4'h4, d); check("R2 readback", d, 32'h8000_0004);
    wait_cyc(31); check("R3 before edge", {31'd0, rst_req_o}, 0);
    wait_cyc(1);  check("R3 edge", {31'd0, rst_req_o}, 1);
    rd(4'h8, d);  check("R3 cause", d, 1);
    wait_cyc(15); check("R7 last high", {31'd0, rst_req_o}, 1);
    wait_cyc(1);  check("R7 low after 16", {31'd0, rst_req_o}, 0);
    rd(4'h8, d);  check("R8 cause held", d, 1);
  endtask

  task automatic t_kick_alive();
    hard_reset();
    wr(4'h4, 32'h8000_0003);
    for (int i = 0; i < 8; i++) begin
      wait_cyc(8);
      wr(4'h8, KA);
      wr(4'hC, KB);
    end
    wait_cyc(8);
    check("R4 no request while fed", {31'd0, saw_req}, 0);
  endtask

  task automatic t_bad_kick(input int kind);
    logic [31:0] d;
    hard_reset();
    case (kind)
      0: wr(4'h8, 32'h1234_5678);
      1: wr(4'hC, KB);
      default: begin wr(4'h8, KA); wr(4'hC, 32'h0); end
    endcase
    check("R5 request", {31'd0, rst_req_o}, 1);
    rd(4'h8, d); check("R5 cause", d, 2);
  endtask

  task automatic t_soft();
    logic [31:0] d;
    hard_reset();
    wr(4'h0, 32'hFFFF_FFFE);
    wait_cyc(3);
    check("R6 bit0 clear ignored", {31'd0, saw_req}, 0);
    rd(4'h8, d); check("R6 cause untouched", d, 0);
    wr(4'h0, 32'h1);
    check("R6 request", {31'd0, rst_req_o}, 1);
    rd(4'h8, d); check("R6 cause", d, 3);
    wait_cyc(20);
    rd(4'h8, d); check("R8 cause after request", d, 3);
    hard_reset();
    rd(4'h8, d); check("R8 hard reset clears", d, 0);
  endtask

  task automatic t_user();
    logic [31:0] d;
    hard_reset();
    user_rst_i = 1'b1;
    wait_cyc(1);
    user_rst_i = 1'b0;
    rd(4'h8, d); check("R9 cause", d, 4);
    wait_cyc(2);
    check("R9 no request", {31'd0, saw_req}, 0);
  endtask

  task automatic t_disable_pending();
    logic [31:0] d;
    hard_reset();
    wr(4'h4, 32'h8000_0003);
    wr(4'h4, 32'h0000_0003);
    rd(4'h4, d); check("R10 cfg disabled", d, 3);
    wait_cyc(15); check("R10 before edge", {31'd0, rst_req_o}, 0);
    wait_cyc(1);  check("R10 still times out", {31'd0, rst_req_o}, 1);
    wr(4'h8, KA);
    wr(4'hC, KB);
    wait_cyc(20);
    saw_req = 1'b0;
    wait_cyc(80);
    check("R10 stopped after kick", {31'd0, saw_req}, 0);
  endtask

  task automatic t_never_enabled();
    hard_reset();
    wr(4'h4, 32'h0000_0000);
    wait_cyc(100);
    check("R11 no timeout", {31'd0, saw_req}, 0);
  endtask

  task automatic t_reload();
    hard_reset();
    wr(4'h4, 32'h8000_0004);
    wait_cyc(20);
    wr(4'h4, 32'h8000_0003);
    wait_cyc(15); check("R12 old period ignored", {31'd0, saw_req}, 0);
    wait_cyc(1);  check("R12 new period", {31'd0, rst_req_o}, 1);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_cfg_timeout();
    t_kick_alive();
    t_bad_kick(0);
    t_bad_kick(1);
    t_bad_kick(2);
    t_soft();
    t_user();
    t_disable_pending();
    t_never_enabled();
    t_reload();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule